// File: doc/BRIEF.md
# Program Counter and Next-Address Unit

This block sits beside a small pipelined processor datapath and decides, every cycle, which address the memory port presents next. It keeps the program counter and one DMA pointer as two entries of a sixteen-word storage array. One adder serves every address step. It adds either the fixed fetch step of 2 or a doubled, sign-extended 8-bit branch offset to the entry being used. The control unit then chooses the address source. The options are the stepped value for fetch and taken branches, the ALU effective address for loads, stores and jumps, the DMA pointer for a DMA cycle, or zero at start-up.

A write enable decides whether the chosen value is stored back. On fetch and jump cycles the program counter takes the issued address. On a DMA cycle the DMA pointer moves on by 2 and the program counter keeps its value. A separate return-address register takes a copy of the program counter when the control unit asks for one, for jump-and-link and call.

Top module: `pc_addr_unit`

## Requirements
- R1: With sel_pc=1, branch=0, dma=0 and zero=0, next_addr equals the program counter plus 2. When pc_ce=1, the program counter holds that value after the clock edge. Example: a counter of 6 gives address 8, and the counter then becomes 8.
- R2: With sel_pc=1 and branch=1, next_addr equals the program counter plus two times br_disp. br_disp is read as a signed 8-bit two's-complement value, in the range -128 to 127.
- R3: With sel_pc=0, dma=0 and zero=0, next_addr equals alu_sum. When pc_ce=1, the program counter takes alu_sum, as in a jump.
- R4: With sel_pc=0 and pc_ce=0, which is a load or store cycle, the program counter does not change.
- R5: zero=1 drives next_addr to 0 whatever the other controls are. With pc_ce=1 it also writes 0 into the program counter. It takes priority over dma.
- R6: With dma=1 and zero=0, next_addr equals the DMA pointer, which is array entry 1. With pc_ce=1 the pointer becomes its old value plus 2. The program counter is left unchanged, and branch has no effect.
- R7: With ret_ce=1, ret_addr takes the program counter value from before that edge. With ret_ce=0, ret_addr holds its value.
- R8: All address arithmetic wraps modulo 2^16. For example, 0xFFFE plus 2 gives 0x0000.
- R9: While rst_n is low, every array entry and ret_addr read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alu_sum | input | 16 | Effective address from the ALU adder |
| br_disp | input | 8 | Signed branch offset in instruction words |
| branch | input | 1 | Add the doubled offset instead of 2 |
| sel_pc | input | 1 | Issue the stepped value rather than alu_sum |
| pc_ce | input | 1 | Write back the selected array entry |
| dma | input | 1 | Use the DMA pointer entry for this cycle |
| zero | input | 1 | Force the address and program counter to 0 |
| ret_ce | input | 1 | Capture the program counter into ret_addr |
| next_addr | output | 16 | Address for the next memory access |
| ret_addr | output | 16 | Captured return address |

## Verification
Two functions can share a cycle: a DMA cycle that steps the pointer, and a return capture that copies the program counter. The random stream sets dma and ret_ce on their own. Their overlaps are therefore frequent, and a directed case also forces one. In each overlap the bench checks that ret_addr holds the untouched program counter, and that the pointer has advanced by exactly 2. A second overlap, zero together with dma, is judged by the address being 0 and the DMA pointer staying intact.

// File: rtl/pcau_pkg.sv
package pcau_pkg;
    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,
        SRC_DMA  = 2'd1,
        SRC_STEP = 2'd2,
        SRC_EA   = 2'd3
    } addr_src_e;
endpackage

// File: rtl/pcau_incr.sv
module pcau_incr #(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 8
) (
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] disp,
    input  logic          use_disp,
    output logic [AW-1:0] sum
);
    localparam int unsigned PADW = AW - DW - 1;

    logic [AW-1:0] step;

    always_comb begin
        if (use_disp) begin
            step = {{PADW{disp[DW-1]}}, disp, 1'b0};
        end else begin
            step = AW'(2);
        end
        sum = base + step;
    end
endmodule

// File: rtl/pcau_sel.sv
module pcau_sel
    import pcau_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  addr_src_e     src,
    input  logic [AW-1:0] stepped,
    input  logic [AW-1:0] ea,
    input  logic [AW-1:0] ptr,
    output logic [AW-1:0] addr
);
    always_comb begin
        unique case (src)
            SRC_ZERO: addr = '0;
            SRC_DMA:  addr = ptr;
            SRC_STEP: addr = stepped;
            default:  addr = ea;
        endcase
    end
endmodule

// File: rtl/pcau_file.sv
module pcau_file #(
    parameter int unsigned AW      = 16,
    parameter int unsigned ENTRIES = 16,
    localparam int unsigned IW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] idx,
    input  logic          we,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] rdata,
    output logic [AW-1:0] pc_val
);
    typedef struct packed {
        logic [ENTRIES-1:0][AW-1:0] ent;
    } file_t;

    file_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.ent[idx] = wdata;
        end
        rdata  = st_q.ent[idx];
        pc_val = st_q.ent[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: writes to another entry leave the program counter alone
    assert_other_entry_keeps_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx != '0) |=> (pc_val == $past(pc_val)));

    // R4: no write, entry read next cycle unchanged
    assert_no_write_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!we) |=> (pc_val == $past(pc_val)));
endmodule

// File: rtl/pc_addr_unit.sv
module pc_addr_unit
    import pcau_pkg::*;
#(
    parameter int unsigned AW        = 16,
    parameter int unsigned DW        = 8,
    parameter int unsigned ENTRIES   = 16,
    parameter int unsigned DMA_ENTRY = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [15:0]   alu_sum,
    input  logic [7:0]    br_disp,
    input  logic          branch,
    input  logic          sel_pc,
    input  logic          pc_ce,
    input  logic          dma,
    input  logic          zero,
    input  logic          ret_ce,
    output logic [15:0]   next_addr,
    output logic [15:0]   ret_addr
);
    localparam int unsigned IW = $clog2(ENTRIES);

    typedef struct packed {
        logic [AW-1:0] ret;
    } ret_t;

    ret_t          st_d, st_q;
    addr_src_e     src;
    logic [IW-1:0] idx;
    logic          use_disp;
    logic [AW-1:0] cur, pc_val, stepped, addr, wdata;

    always_comb begin
        if (zero) begin
            src = SRC_ZERO;
        end else if (dma) begin
            src = SRC_DMA;
        end else if (sel_pc) begin
            src = SRC_STEP;
        end else begin
            src = SRC_EA;
        end
        idx      = (src == SRC_DMA) ? IW'(DMA_ENTRY) : '0;
        use_disp = branch && (src != SRC_DMA);
    end

    pcau_file #(.AW(AW), .ENTRIES(ENTRIES)) u_file (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx    (idx),
        .we     (pc_ce),
        .wdata  (wdata),
        .rdata  (cur),
        .pc_val (pc_val)
    );

    pcau_incr #(.AW(AW), .DW(DW)) u_incr (
        .base     (cur),
        .disp     (br_disp),
        .use_disp (use_disp),
        .sum      (stepped)
    );

    pcau_sel #(.AW(AW)) u_sel (
        .src     (src),
        .stepped (stepped),
        .ea      (alu_sum),
        .ptr     (cur),
        .addr    (addr)
    );

    always_comb begin
        wdata = (src == SRC_DMA) ? stepped : addr;
        st_d  = st_q;
        if (ret_ce) begin
            st_d.ret = pc_val;
        end
        next_addr = addr;
        ret_addr  = st_q.ret;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_zero_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        zero |-> (next_addr == '0));

    assert_ea_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero && !dma && !sel_pc) |-> (next_addr == alu_sum));

    assert_fetch_updates_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_ce && sel_pc && !zero && !dma) |=> (pc_val == $past(next_addr)));

    assert_ret_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ret_ce |=> (ret_addr == $past(pc_val)));

    assert_ret_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_ce |=> $stable(ret_addr));
endmodule

// File: tb/pc_addr_unit_bench.sv
`timescale 1ns/1ps
module pc_addr_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] alu_sum = '0;
    logic [7:0]  br_disp = '0;
    logic        branch = 1'b0, sel_pc = 1'b1, pc_ce = 1'b0, dma = 1'b0;
    logic        zero = 1'b0, ret_ce = 1'b0;
    logic [15:0] next_addr, ret_addr;

    int unsigned errors = 0;
    int unsigned checks = 0;
    bit          finished = 1'b0;

    logic [15:0] m_pc = '0, m_dp = '0, m_ret = '0;

    always #2 clk = ~clk;

    pc_addr_unit u_pc_addr_unit (
        .clk(clk), .rst_n(rst_n), .alu_sum(alu_sum), .br_disp(br_disp),
        .branch(branch), .sel_pc(sel_pc), .pc_ce(pc_ce), .dma(dma),
        .zero(zero), .ret_ce(ret_ce), .next_addr(next_addr), .ret_addr(ret_addr)
    );

    function automatic logic [15:0] exp_addr(logic z, logic d, logic s, logic b,
                                             logic [7:0] disp, logic [15:0] ea);
        logic [15:0] step;
        step = b ? ({{8{disp[7]}}, disp} << 1) : 16'd2;
        if (z)      return 16'h0000;
        else if (d) return m_dp;
        else if (s) return m_pc + step;
        else        return ea;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(logic z, logic d, logic s, logic b, logic [7:0] disp,
                       logic [15:0] ea, logic ce, logic rce, string tag);
        logic [15:0] e;
        string r;
        @(negedge clk);
        zero = z; dma = d; sel_pc = s; branch = b; br_disp = disp;
        alu_sum = ea; pc_ce = ce; ret_ce = rce;
        #1;
        e = exp_addr(z, d, s, b, disp, ea);
        if (tag != "")  r = tag;
        else if (z)     r = "R5";
        else if (d)     r = "R6";
        else if (s && b) r = "R2";
        else if (s)     r = "R1";
        else if (ce)    r = "R3";
        else            r = "R4";
        check(r, next_addr, e);
        if (rce) m_ret = m_pc;
        if (ce) begin
            if (z)      m_pc = 16'h0000;
            else if (d) m_dp = m_dp + 16'd2;
            else        m_pc = e;
        end
        @(posedge clk);
        #1;
        check("R7", ret_addr, m_ret);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        #1;
        // R9: reset state
        check("R9", ret_addr, 16'h0000);
        check("R9", next_addr, 16'h0002);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R5: start-up force zero
        cyc(1, 0, 1, 0, 8'h00, 16'h1234, 1, 0, "");
        // R1: 0 -> 2 -> 4 -> 6, then 6 gives 8
        cyc(0, 0, 1, 0, 8'h00, 16'h0, 1, 0, "");
        cyc(0, 0, 1, 0, 8'h00, 16'h0, 1, 0, "");
        cyc(0, 0, 1, 0, 8'h00, 16'h0, 1, 0, "");
        cyc(0, 0, 1, 0, 8'h00, 16'h0, 1, 1, "R1");
        check("R1", m_pc, 16'h0008);
        // R2: extreme offsets
        cyc(0, 0, 1, 1, 8'h80, 16'h0, 0, 0, "R2");
        cyc(0, 0, 1, 1, 8'h7F, 16'h0, 1, 0, "R2");
        // R4: load/store keeps counter
        cyc(0, 0, 0, 0, 8'h00, 16'hBEEF, 0, 0, "R4");
        cyc(0, 0, 0, 0, 8'h00, 16'hBEEF, 0, 1, "R4");
        // R3 and R8: jump near the top, then wrap
        cyc(0, 0, 0, 0, 8'h00, 16'hFFFE, 1, 0, "R3");
        cyc(0, 0, 1, 0, 8'h00, 16'h0, 1, 0, "R8");
        // R6: DMA with branch set, overlapped with return capture
        cyc(0, 1, 0, 1, 8'h05, 16'h0, 1, 1, "R6");
        cyc(0, 1, 1, 0, 8'h00, 16'h0, 0, 0, "R6");
        cyc(0, 0, 1, 0, 8'h00, 16'h0, 0, 0, "R6");
        // R5: zero overrides DMA
        cyc(1, 1, 1, 0, 8'h00, 16'h0, 0, 0, "R5");
        cyc(0, 1, 1, 0, 8'h00, 16'h0, 0, 0, "R5");
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[4:0] == 0, r[7:5] < 2, r[8], r[9], r[17:10], $urandom,
                r[18] | r[19], r[20] & r[21], "");
        end
        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule